// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets a clocked host read and write single bytes in an external asynchronous static RAM of 128K bytes. The host presents a request with a valid/ready handshake: a direction bit, a 17-bit byte address and, for writes, a data byte. The sequencer then drives the memory's address lines, a pair of chip selects of opposite polarity, the write strobe, the output strobe and a split bidirectional data bus (outgoing byte, incoming byte, driver enable). A read returns its byte with a one-cycle response strobe.

Every phase length is a whole number of clock cycles. Each is computed when the block is elaborated, from the clock period and a nanosecond figure taken from the memory's speed grade. The grade is picked by supply voltage. When the direction changes between two requests, the sequencer puts a quiet gap on the bus before the second access. Between requests, every memory input stays exactly where it was: the address does not move and the selects return to standby. The reason is that address motion alone makes the memory draw active current.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, mem_ce_n is 1, mem_ce is 0, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: mem_ce_n and mem_ce are always complementary. They select the memory only during the access and write-recovery cycles of a request, and mem_addr then equals the accepted request address.
- R3: A read keeps mem_oe_n low, mem_we_n high and mem_dq_oe low for exactly AA = max(1, ceil(T_AA_NS / CLK_NS)) cycles. It samples mem_dq_in at the end of the last of them. The sampled byte is presented on rsp_rdata with rsp_valid high for exactly one cycle.
- R4: A write keeps mem_we_n low, with mem_dq_oe high and mem_dq_out equal to the request byte, for exactly max(AA_wp, AA_dw) cycles. Here AA_wp = max(1, ceil(T_WP_NS / CLK_NS)) and AA_dw = max(1, ceil(T_DW_NS / CLK_NS)). One recovery cycle follows, with mem_we_n high and the memory still selected and driven. mem_oe_n stays high throughout.
- R5: mem_dq_oe is never 1 while mem_oe_n is 0, and mem_we_n and mem_oe_n are never both 0.
- R6: req_ready is 0 from the cycle after a request is accepted until the access, including any gap, has completed. A request is accepted only in a cycle where req_ready is 1.
- R7: While no request is pending, mem_addr, mem_ce_n, mem_we_n, mem_oe_n and mem_dq_oe hold their values. The address keeps the last accessed value.
- R8: When a request's direction differs from the previous accepted request, TA = max(1, ceil(T_TA_NS / CLK_NS)) cycles come before the access. In those cycles the memory is deselected, both strobes are high and mem_dq_oe is 0.
- R9: A request in the same direction as the previous one, or the first request after reset, starts its access in the cycle right after acceptance, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 17 | Memory address lines |
| mem_ce_n | output | 1 | Active-low memory select |
| mem_ce | output | 1 | Active-high memory select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_in | input | 8 | Byte sampled from the data bus |
| mem_dq_oe | output | 1 | Data bus driver enable |

## Verification
The bench builds the block with a 15 ns clock and a 25 ns turnaround figure, which gives a 5-cycle read access, a 3-cycle write pulse and a 2-cycle gap. These values make the ceiling rounding matter. The write pulse is set by the pulse-width term rather than the data-setup term, and the gap is longer than one cycle, so a count that is off by one or uses the wrong term changes an observed length. Its memory model returns a poison byte until the output strobe has been low for the full access count, so sampling a cycle early is visible on rsp_rdata.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TURN  = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_WREC  = 3'd4
  } seq_state_e;

  // Whole clock cycles covering a nanosecond figure, never fewer than one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned clk_ns);
    int unsigned q;
    q = (ns + clk_ns - 1) / clk_ns;
    return (q == 0) ? 1 : q;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold values 0..v.
  function automatic int unsigned bits_for(input int unsigned v);
    int unsigned n;
    n = 1;
    while ((v >> n) != 0) n++;
    return n;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R3: an expired count stays expired until reloaded
  a_r3_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);

endmodule

// File: rtl/sram_bus_drive.sv
module sram_bus_drive
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  logic sel_d, we_d, oe_d, drv_d;
  logic sel_q, we_q, oe_q, drv_q;

  // Pin levels decoded from the next state, registered so the pins never glitch.
  always_comb begin
    sel_d = (state_d == ST_READ) || (state_d == ST_WRITE) || (state_d == ST_WREC);
    we_d  = (state_d == ST_WRITE);
    oe_d  = (state_d == ST_READ);
    drv_d = (state_d == ST_WRITE) || (state_d == ST_WREC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= 1'b0;
      we_q       <= 1'b0;
      oe_q       <= 1'b0;
      drv_q      <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else begin
      sel_q <= sel_d;
      we_q  <= we_d;
      oe_q  <= oe_d;
      drv_q <= drv_d;
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
    end
  end

  assign mem_ce_n  = !sel_q;
  assign mem_ce    = sel_q;
  assign mem_we_n  = !we_q;
  assign mem_oe_n  = !oe_q;
  assign mem_dq_oe = drv_q;

  // R4: write byte does not move while the write strobe is low
  a_r4_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

  // R4: address does not move while the memory is selected
  a_r4_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned T_AA_NS = 70,
  parameter int unsigned T_WP_NS = 35,
  parameter int unsigned T_DW_NS = 20,
  parameter int unsigned T_TA_NS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int unsigned AA_CYC  = ns_to_cycles(T_AA_NS, CLK_NS);
  localparam int unsigned WP_CYC  = max_u(ns_to_cycles(T_WP_NS, CLK_NS),
                                          ns_to_cycles(T_DW_NS, CLK_NS));
  localparam int unsigned TA_CYC  = ns_to_cycles(T_TA_NS, CLK_NS);
  localparam int unsigned MAX_CYC = max_u(AA_CYC, max_u(WP_CYC, TA_CYC));
  localparam int unsigned CNT_W   = bits_for(MAX_CYC);

  seq_state_e       state_q, state_d;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic             last_vld_q, last_wr_q;

  // Named events for assertions
  logic accept_evt, read_sample_evt, write_end_evt, dir_change_evt;

  assign req_ready       = (state_q == ST_IDLE);
  assign accept_evt      = req_valid && req_ready;
  assign dir_change_evt  = accept_evt && last_vld_q && (last_wr_q != req_write);
  assign read_sample_evt = (state_q == ST_READ) && tmr_done;
  assign write_end_evt   = (state_q == ST_WRITE) && tmr_done;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_evt) begin
          tmr_load = 1'b1;
          if (dir_change_evt) begin
            state_d = ST_TURN;
            tmr_val = CNT_W'(TA_CYC - 1);
          end else if (req_write) begin
            state_d = ST_WRITE;
            tmr_val = CNT_W'(WP_CYC - 1);
          end else begin
            state_d = ST_READ;
            tmr_val = CNT_W'(AA_CYC - 1);
          end
        end
      end
      ST_TURN: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          if (last_wr_q) begin
            state_d = ST_WRITE;
            tmr_val = CNT_W'(WP_CYC - 1);
          end else begin
            state_d = ST_READ;
            tmr_val = CNT_W'(AA_CYC - 1);
          end
        end
      end
      ST_READ:  if (tmr_done) state_d = ST_IDLE;
      ST_WRITE: if (tmr_done) state_d = ST_WREC;
      ST_WREC:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      last_vld_q <= 1'b0;
      last_wr_q  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= read_sample_evt;
      if (read_sample_evt) rsp_rdata <= mem_dq_in;
      if (accept_evt) begin
        last_vld_q <= 1'b1;
        last_wr_q  <= req_write;
      end
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) bus_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_d    (state_d),
    .accept     (accept_evt),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_ce     (mem_ce),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

  a_r2_select_pair: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce == !mem_ce_n);

  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  a_r3_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r4_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    write_end_evt |=> (mem_we_n && !mem_ce_n && mem_dq_oe));

  a_r7_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> ($stable(mem_addr) && $stable(mem_ce_n) &&
                                   $stable(mem_we_n) && $stable(mem_oe_n) &&
                                   $stable(mem_dq_oe)));

  a_r8_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dir_change_evt |=> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;

  localparam int CLK_NS  = 15;
  localparam int T_AA_NS = 70;
  localparam int T_WP_NS = 35;
  localparam int T_DW_NS = 20;
  localparam int T_TA_NS = 25;

  // Expected counts, worked out from the requirement text
  localparam int EXP_AA = ((T_AA_NS + CLK_NS - 1) / CLK_NS < 1) ? 1 : (T_AA_NS + CLK_NS - 1) / CLK_NS;
  localparam int EXP_WA = ((T_WP_NS + CLK_NS - 1) / CLK_NS < 1) ? 1 : (T_WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int EXP_WB = ((T_DW_NS + CLK_NS - 1) / CLK_NS < 1) ? 1 : (T_DW_NS + CLK_NS - 1) / CLK_NS;
  localparam int EXP_WP = (EXP_WA > EXP_WB) ? EXP_WA : EXP_WB;
  localparam int EXP_TA = ((T_TA_NS + CLK_NS - 1) / CLK_NS < 1) ? 1 : (T_TA_NS + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_NS / 2.0) clk = ~clk;

  sram_async_ctrl #(
    .CLK_NS(CLK_NS), .T_AA_NS(T_AA_NS), .T_WP_NS(T_WP_NS),
    .T_DW_NS(T_DW_NS), .T_TA_NS(T_TA_NS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  // Small memory model: 32 bytes on the low address bits, poison until access time
  logic [7:0] model_mem [32];
  int         oe_low_cnt = 0;
  bit         model_en = 0;
  wire        model_sel = !mem_ce_n && mem_ce;

  always @(negedge clk) begin
    if (mem_oe_n) oe_low_cnt <= 0;
    else          oe_low_cnt <= oe_low_cnt + 1;
  end

  always @(posedge mem_we_n) begin
    if (model_en && model_sel) model_mem[mem_addr[4:0]] <= mem_dq_out;
  end

  assign mem_dq_in = (model_sel && mem_we_n && !mem_oe_n && oe_low_cnt >= EXP_AA)
                     ? model_mem[mem_addr[4:0]] : 8'hEE;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  // One request; returns observed phase lengths
  task automatic run_txn(input bit wr, input logic [16:0] a, input logic [7:0] d,
                         input bit exp_gap, input logic [7:0] exp_rd);
    int gap = 0, we_lo = 0, oe_lo = 0, rec = 0, clash = 0, rsp_n = 0, bad_addr = 0;
    int bad_data = 0;
    logic [7:0] got = 8'h00;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (rsp_valid) begin rsp_n++; got = rsp_rdata; end
      if (req_ready) break;
      if (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe) gap++;
      if (!mem_we_n) begin
        we_lo++;
        if (!mem_dq_oe || mem_dq_out != d) bad_data++;
      end
      if (!mem_oe_n) oe_lo++;
      if (!mem_ce_n && mem_we_n && mem_dq_oe) rec++;
      if (mem_dq_oe && !mem_oe_n) clash++;
      if (!mem_we_n && !mem_oe_n) clash++;
      if (!mem_ce_n && mem_addr != a) bad_addr++;
      if (mem_ce_n == mem_ce) bad_addr++;
      @(negedge clk);
    end
    if (rsp_valid && req_ready) begin
      @(negedge clk);
      if (rsp_valid) rsp_n++;
    end
    if (exp_gap) check("R8", "gap cycles", gap, EXP_TA);
    else         check("R9", "gap cycles", gap, 0);
    check("R5", "contention cycles", clash, 0);
    check("R2", "select/address faults", bad_addr, 0);
    if (wr) begin
      check("R4", "write strobe cycles", we_lo, EXP_WP);
      check("R4", "recovery cycles", rec, 1);
      check("R4", "output strobe cycles", oe_lo, 0);
      check("R4", "write data faults", bad_data, 0);
    end else begin
      check("R3", "output strobe cycles", oe_lo, EXP_AA);
      check("R3", "write strobe cycles", we_lo, 0);
      check("R3", "response pulses", rsp_n, 1);
      check("R3", "read byte", got, exp_rd);
    end
  endtask

  // {write, addr, data}
  localparam int NV = 8;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 17'h00003, 8'hA5},
    {1'b1, 17'h1FFFF, 8'h3C},
    {1'b0, 17'h00003, 8'hA5},
    {1'b0, 17'h1FFFF, 8'h3C},
    {1'b1, 17'h10005, 8'hFF},
    {1'b1, 17'h00006, 8'h00},
    {1'b0, 17'h10005, 8'hFF},
    {1'b0, 17'h00006, 8'h00}
  };

  initial begin
    logic [16:0] a_hold;
    bit prev_vld;
    bit prev_wr;
    for (int i = 0; i < 32; i++) model_mem[i] = 8'h5A;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "mem_ce_n", mem_ce_n, 1);
    check("R1", "mem_ce", mem_ce, 0);
    check("R1", "mem_we_n", mem_we_n, 1);
    check("R1", "mem_oe_n", mem_oe_n, 1);
    check("R1", "mem_dq_oe", mem_dq_oe, 0);
    check("R1", "req_ready", req_ready, 1);
    check("R1", "rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    model_en = 1;
    repeat (2) @(negedge clk);

    prev_vld = 0;
    prev_wr  = 0;
    for (int v = 0; v < NV; v++) begin
      bit w;
      w = VEC[v][25];
      run_txn(w, VEC[v][24:8], VEC[v][7:0], prev_vld && (prev_wr != w), VEC[v][7:0]);
      prev_vld = 1;
      prev_wr  = w;
    end

    // R7: idle hold after the last access
    a_hold = mem_addr;
    check("R7", "address kept after access", mem_addr, 17'h00006);
    repeat (6) @(negedge clk);
    check("R7", "address frozen", mem_addr, a_hold);
    check("R7", "strobes idle", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    check("R6", "ready while idle", req_ready, 1);

    // R6: request held during a busy access is not taken twice
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00003;
    @(posedge clk);
    @(negedge clk);
    check("R6", "ready low after accept", req_ready, 0);
    req_valid = 1'b0;
    repeat (EXP_AA + 3) @(negedge clk);
    check("R6", "single access, back to idle", req_ready, 1);
    check("R3", "read byte after held request", rsp_rdata, 8'hA5);

    finished = 1;
    report();
    $finish;
  end

endmodule